// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory array and watches the left and right access ports. Each port presents a chip enable, an address and a write request. When both ports are enabled on the same address, the arbiter decides which port owns the location. It drives an active-low busy flag to the port that lost, and it suppresses that port's write strobe toward the array. Reads are never held back, so the array may still serve a read from the losing port.

A mode input chooses between master and slave operation. In master mode the block makes the decision itself and drives both busy flags. In slave mode it follows busy flags that an external master supplies. Its own busy outputs then stay inactive, and a low incoming flag only blocks that port's writes. This lets several arbiters on a wide memory follow a single decision. All logic runs in one clock domain.

Top module: `dp_collision_arb`

## Requirements
- R1: A collision exists only when both chip enables are high and both addresses are equal. The write request inputs take no part in detection: a collision with both write requests low still drives the loser's busy low on the next clock edge.
- R2: The port whose enable and address were already unchanged in the previous cycle wins over a port that has just arrived. The loser's busy output goes low at the clock edge that ends the first colliding cycle.
- R3: If both ports change to the colliding access in the same cycle, the left port wins and the right busy goes low.
- R4: The two busy outputs are never low at the same time.
- R5: A port's write strobe (`*_wr_o` = enable AND write request AND NOT inhibit) is held low while it loses a collision. This includes the first colliding cycle, before its busy flag goes low, and every cycle its busy flag is low. The winner's write strobe is not affected.
- R6: Once chosen, the winner stays fixed for as long as both ports keep the same enable and address.
- R7: When the winner drops its enable or changes its address, the loser's busy returns high at the next clock edge. If the ports then collide at a new address, the arbiter decides again with the R2/R3 rules.
- R8: In slave mode (`master_i` = 0), both busy outputs are high. A low busy input blocks that port's write strobe in the same cycle.
- R9: In slave mode with both busy inputs high, no write is inhibited, even during an address collision.
- R10: After reset both busy outputs are high. Addresses up to the highest value (all ones) are compared like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (decide locally), 0 = slave (follow busy inputs) |
| l_ce_i | input | 1 | Left chip enable |
| l_addr_i | input | ADDR_W | Left address |
| l_we_i | input | 1 | Left write request |
| r_ce_i | input | 1 | Right chip enable |
| r_addr_i | input | ADDR_W | Right address |
| r_we_i | input | 1 | Right write request |
| l_busy_ni | input | 1 | Left busy from external master, active low (slave mode) |
| r_busy_ni | input | 1 | Right busy from external master, active low (slave mode) |
| l_busy_no | output | 1 | Left busy, active low, registered |
| r_busy_no | output | 1 | Right busy, active low, registered |
| l_inhibit_o | output | 1 | Left write inhibit toward the array |
| r_inhibit_o | output | 1 | Right write inhibit toward the array |
| l_wr_o | output | 1 | Left gated write strobe |
| r_wr_o | output | 1 | Right gated write strobe |

## Verification
The bench builds the block with the default address width of 12 bits. At this width it can reach both the all-zero and all-ones addresses, and pairs that differ only in the top bit, which would alias if the comparator were truncated. A behavioural model runs beside the block. It records the cycle in which each port last changed its access and ranks the ports by that timestamp. Each cycle it predicts the strobes and inhibits before the edge and the busy flags after it. The scenarios cover staggered and simultaneous arrival, read-only collisions, a winner that moves onto a waiting port, and slave-mode flag patterns.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpca_track.sv
// Flags a port whose enable and address are unchanged since last cycle.
module dpca_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              held_o
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce_i;
      addr_q <= addr_i;
    end
  end

  assign held_o = ce_i && ce_q && (addr_i == addr_q);
endmodule

// File: rtl/dpca_owner.sv
module dpca_owner
  import dpca_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   coll_i,
  input  logic   l_held_i,
  input  logic   r_held_i,
  output owner_e owner_nxt_o,
  output logic   l_busy_no,
  output logic   r_busy_no
);
  owner_e owner_q;

  always_comb begin
    if (!coll_i)
      owner_nxt_o = OWN_NONE;
    else if (owner_q != OWN_NONE && l_held_i && r_held_i)
      owner_nxt_o = owner_q;
    else if (r_held_i && !l_held_i)
      owner_nxt_o = OWN_RIGHT;
    else
      owner_nxt_o = OWN_LEFT;  // earlier left, or tie
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= OWN_NONE;
      l_busy_no <= 1'b1;
      r_busy_no <= 1'b1;
    end else begin
      owner_q   <= owner_nxt_o;
      l_busy_no <= (owner_nxt_o != OWN_RIGHT);
      r_busy_no <= (owner_nxt_o != OWN_LEFT);
    end
  end

  // R6
  owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != OWN_NONE && coll_i && l_held_i && r_held_i) |=> $stable(owner_q));

  // R7
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_busy_no && !coll_i) |=> r_busy_no);

  // R3
  tie_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && !l_held_i && !r_held_i) |=> (l_busy_no && !r_busy_no));
endmodule

// File: rtl/dpca_gate.sv
// Per-port write gating; source of the busy flag depends on mode.
module dpca_gate (
  input  logic master_i,
  input  logic busy_int_ni,
  input  logic claim_other_i,
  input  logic busy_ext_ni,
  input  logic ce_i,
  input  logic we_i,
  output logic inhibit_o,
  output logic wr_o
);
  always_comb begin
    if (master_i)
      inhibit_o = !busy_int_ni || claim_other_i;
    else
      inhibit_o = !busy_ext_ni;
  end

  assign wr_o = ce_i && we_i && !inhibit_o;
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_ce_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_i,
  input  logic              r_ce_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic              l_busy_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_inhibit_o,
  output logic              r_inhibit_o,
  output logic              l_wr_o,
  output logic              r_wr_o
);
  logic   coll, l_held, r_held;
  logic   l_busy_q, r_busy_q;
  owner_e owner_nxt;

  // R1: enable and address only
  assign coll = l_ce_i && r_ce_i && (l_addr_i == r_addr_i);

  dpca_track #(.ADDR_W(ADDR_W)) l_trk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(l_ce_i), .addr_i(l_addr_i), .held_o(l_held));
  dpca_track #(.ADDR_W(ADDR_W)) r_trk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(r_ce_i), .addr_i(r_addr_i), .held_o(r_held));

  dpca_owner own_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .coll_i(coll),
    .l_held_i(l_held), .r_held_i(r_held),
    .owner_nxt_o(owner_nxt), .l_busy_no(l_busy_q), .r_busy_no(r_busy_q));

  dpca_gate l_gate_i (
    .master_i(master_i), .busy_int_ni(l_busy_q),
    .claim_other_i(owner_nxt == OWN_RIGHT), .busy_ext_ni(l_busy_ni),
    .ce_i(l_ce_i), .we_i(l_we_i), .inhibit_o(l_inhibit_o), .wr_o(l_wr_o));
  dpca_gate r_gate_i (
    .master_i(master_i), .busy_int_ni(r_busy_q),
    .claim_other_i(owner_nxt == OWN_LEFT), .busy_ext_ni(r_busy_ni),
    .ce_i(r_ce_i), .we_i(r_we_i), .inhibit_o(r_inhibit_o), .wr_o(r_wr_o));

  assign l_busy_no = master_i ? l_busy_q : 1'b1;
  assign r_busy_no = master_i ? r_busy_q : 1'b1;

  // R4
  no_dual_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no));

  // R5
  loser_wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_no || !r_busy_no) |-> !(l_busy_no ? r_wr_o : l_wr_o));

  // R8
  slave_wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !r_busy_ni) |-> !r_wr_o);

  // R7
  busy_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $fell(l_busy_no)) |-> $past(coll));
endmodule

// File: tb/dp_collision_arb_tb_top.sv
module dp_collision_arb_tb_top;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master = 1'b1;
  logic          l_ce = 0, r_ce = 0, l_we = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_bi = 1, r_bi = 1;
  logic          l_bo, r_bo, l_inh, r_inh, l_wr, r_wr;

  int checks = 0, errors = 0;

  // model state
  int  cyc = 0;
  int  st_l = 0, st_r = 0;
  bit  pl_ce = 0, pr_ce = 0;
  int  pl_a = 0, pr_a = 0;
  int  own = 0;              // 0 none, 1 left, 2 right
  bit  mb_l = 1, mb_r = 1;   // model internal busy_n

  always #4 clk = ~clk;

  dp_collision_arb #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_ce_i(l_ce), .l_addr_i(l_addr), .l_we_i(l_we),
    .r_ce_i(r_ce), .r_addr_i(r_addr), .r_we_i(r_we),
    .l_busy_ni(l_bi), .r_busy_ni(r_bi),
    .l_busy_no(l_bo), .r_busy_no(r_bo),
    .l_inhibit_o(l_inh), .r_inhibit_o(r_inh),
    .l_wr_o(l_wr), .r_wr_o(r_wr));

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // one clock of stimulus; checks strobes before the edge, busy after it
  task automatic step(string tag, bit m, bit lc, int la, bit lw,
                      bit rc, int ra, bit rw, bit lbi = 1, bit rbi = 1);
    bit lchg, rchg, coll, li, ri;
    int nl, nr, nxt;
    master = m; l_ce = lc; l_addr = la[AW-1:0]; l_we = lw;
    r_ce = rc; r_addr = ra[AW-1:0]; r_we = rw; l_bi = lbi; r_bi = rbi;
    #1;
    lchg = !(lc && pl_ce && la == pl_a);
    rchg = !(rc && pr_ce && ra == pr_a);
    nl = lchg ? cyc : st_l;
    nr = rchg ? cyc : st_r;
    coll = lc && rc && (la == ra);
    if (!coll) nxt = 0;
    else if (own != 0 && !lchg && !rchg) nxt = own;
    else nxt = (nl <= nr) ? 1 : 2;
    if (m) begin
      li = !mb_l || nxt == 2;
      ri = !mb_r || nxt == 1;
    end else begin
      li = !lbi;
      ri = !rbi;
    end
    chk(tag, "l_inhibit", l_inh, li);
    chk(tag, "r_inhibit", r_inh, ri);
    chk(tag, "l_wr", l_wr, lc && lw && !li);
    chk(tag, "r_wr", r_wr, rc && rw && !ri);
    @(posedge clk);
    st_l = nl; st_r = nr; pl_ce = lc; pr_ce = rc; pl_a = la; pr_a = ra;
    own = nxt; mb_l = (nxt != 2); mb_r = (nxt != 1); cyc++;
    @(negedge clk);
    chk(tag, "l_busy", l_bo, m ? mb_l : 1'b1);
    chk(tag, "r_busy", r_bo, m ? mb_r : 1'b1);
    chk("R4", "dual busy", !l_bo && !r_bo, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "l_busy reset", l_bo, 1'b1);
    chk("R10", "r_busy reset", r_bo, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    step("R10", 1, 0, 0, 0, 0, 0, 0);
    // R2 left first, right arrives: right loses, R5 its writes blocked
    step("R2", 1, 1, 5, 1, 0, 0, 0);
    step("R2", 1, 1, 5, 1, 1, 5, 1);
    for (int i = 0; i < 3; i++) step("R6", 1, 1, 5, 1, 1, 5, 1);
    step("R5", 1, 1, 5, 0, 1, 5, 1);
    // R7 winner drops enable
    step("R7", 1, 0, 5, 0, 1, 5, 1);
    step("R7", 1, 0, 5, 0, 1, 5, 1);
    // R3 simultaneous arrival
    step("R3", 1, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 12'hA, 1, 1, 12'hA, 1);
    step("R3", 1, 1, 12'hA, 1, 1, 12'hA, 1);
    // R1 read-only collision after right arrived first
    step("R1", 1, 0, 0, 0, 1, 7, 0);
    step("R1", 1, 1, 7, 0, 1, 7, 0);
    step("R1", 1, 1, 7, 1, 1, 7, 0);
    // R1 distinct addresses, differing only in top bit
    step("R1", 1, 1, 12'h801, 1, 1, 12'h001, 1);
    step("R1", 1, 1, 12'h801, 1, 1, 12'h001, 1);
    // R7 winner moves onto waiting loser's new spot: re-arbitration
    step("R7", 1, 1, 3, 1, 0, 0, 0);
    step("R7", 1, 1, 3, 1, 1, 3, 1);
    step("R7", 1, 1, 9, 1, 1, 3, 1);
    step("R7", 1, 1, 3, 1, 1, 3, 1);
    step("R7", 1, 1, 3, 1, 1, 3, 1);
    // R10 top address
    step("R10", 1, 0, 0, 0, 1, 12'hFFF, 1);
    step("R10", 1, 1, 12'hFFF, 1, 1, 12'hFFF, 1);
    step("R10", 1, 1, 12'hFFF, 1, 1, 12'hFFE, 1);
    // R8 slave mode with external busy
    step("R8", 0, 1, 4, 1, 1, 4, 1, 1, 0);
    step("R8", 0, 1, 4, 1, 1, 4, 1, 0, 1);
    step("R8", 0, 1, 4, 0, 1, 4, 1, 0, 1);
    // R9 slave, both inputs high: nothing inhibited
    step("R9", 0, 1, 4, 1, 1, 4, 1, 1, 1);
    step("R9", 0, 1, 6, 1, 1, 6, 1, 1, 1);
    // back to master
    step("R2", 1, 1, 6, 1, 1, 6, 1);
    step("R2", 1, 0, 0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule